// File: doc/BRIEF.md
# Circuit Path Reservation Router

This block is the electronic control router placed beside one four-port optical crossing switch in a folded-torus on-chip network. Small 32-bit control packets arrive on four links. A setup packet asks for a circuit toward a destination node. The router picks the next hop with dimension-order routing: it finishes the X ring first, then the Y ring, and on each ring it takes the shorter way around. If that output link is free, the router reserves the input-to-output crossing and passes the packet on. If the output is already reserved, the setup packet is dropped at once. In that case a one-cycle drop notice carries the requester's coordinates back so that the source can retry.

A teardown packet follows the same route. It frees the crossing that its own input holds, and the freed link can then carry another circuit. No packet is ever buffered. The only state the router keeps is one small reservation state machine per output and a round-robin pointer. When several inputs present packets in the same cycle, the pointer serves them one per cycle. The router drives sixteen crossing-enable bits, one for each input/output pair, into the optical switch.

The per-output state machine has two states. `CH_FREE` moves to `CH_HELD` on a claim, and `CH_HELD` moves back to `CH_FREE` on a release. The decision for each granted packet is one of six actions: `ACT_IDLE`, `ACT_FWD_SETUP`, `ACT_FWD_TEAR`, `ACT_DROP`, `ACT_ARRIVE` and `ACT_DISCARD`.

Top module: `circuit_router`

## Requirements
- R1: A packet is {kind[31:30], dest X[29:27], dest Y[26:24], source X[23:21], source Y[20:18], unused[17:0]}. Kind 01 is setup and kind 10 is teardown. A granted packet of kind 00 or 11 is consumed with no output, no drop, no arrival and no change of any reservation.
- R2: Output port numbering is 0 = X positive, 1 = X negative, 2 = Y positive, 3 = Y negative. While the destination X differs from the node X, the packet leaves on an X port. Only when X matches does it use a Y port.
- R3: The offset on each ring is (dest − node) mod TORUS_N. An offset from 1 to TORUS_N/2 goes to the positive port, and a larger offset goes to the negative port. An offset of exactly TORUS_N/2 goes positive.
- R4: A setup packet whose routed output is free is presented unchanged on that output's data lane, with its out_valid bit high, for exactly one cycle after the grant edge. From that edge on, sw_on[in*4+out] is 1.
- R5: A setup packet whose routed output is reserved is not forwarded. drop_valid pulses for one cycle with the packet's source X/Y, and sw_on is unchanged.
- R6: A teardown packet whose routed output is reserved by the input it arrives on is forwarded unchanged on that output. It clears that crossing, and the output becomes free for a new setup.
- R7: A teardown packet whose routed output is free, or is reserved by a different input, is discarded with no output and no change to sw_on.
- R8: A setup packet addressed to this node raises arrive_valid for one cycle with its source X/Y and reserves nothing. A teardown packet addressed to this node is consumed with no effect.
- R9: At most one input is granted per cycle. in_gnt is combinational in the same cycle as in_valid. The search starts at the input after the last one granted, and an input holds its packet until it is granted.
- R10: After reset, all outputs are free, sw_on is 0, and no out_valid, drop_valid or arrive_valid is high.
- R11: A crossing bit is 1 only while its connection is reserved, and each output is connected to at most one input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | 3 | X coordinate of this node |
| node_y | input | 3 | Y coordinate of this node |
| in_valid | input | 4 | Packet present on each input link |
| in_pkt | input | 128 | Four 32-bit packets, link i at bits [32i+31:32i] |
| in_gnt | output | 4 | Input taken this cycle |
| out_valid | output | 4 | Packet forwarded on each output link |
| out_pkt | output | 128 | Four 32-bit output lanes, link o at [32o+31:32o] |
| sw_on | output | 16 | Crossing enable, bit in*4+out |
| drop_valid | output | 1 | One-cycle notice that a setup was dropped |
| drop_src_x | output | 3 | Source X of the dropped setup |
| drop_src_y | output | 3 | Source Y of the dropped setup |
| arrive_valid | output | 1 | One-cycle notice that a setup reached this node |
| arrive_src_x | output | 3 | Source X of the arrived setup |
| arrive_src_y | output | 3 | Source Y of the arrived setup |

## Verification
The grant is the only result in the same cycle. The bench reads in_gnt one time step after it raises in_valid on a falling edge. Forwarding, drop and arrival notices, and crossing bits all appear one rising edge after the grant. The bench therefore samples them at the next falling edge, and it samples once more a cycle later to confirm that the notices were single-cycle pulses. For simultaneous requests, the bench releases each input at the falling edge that follows its grant and re-reads in_gnt then. This way the order of service is observed one cycle at a time.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int COORD_W = 3;
    localparam int PKT_W   = 32;
    localparam int NPORT   = 4;
    localparam int PIDX_W  = 2;

    typedef enum logic [1:0] {
        PK_NONE  = 2'b00,
        PK_SETUP = 2'b01,
        PK_TEAR  = 2'b10,
        PK_RSVD  = 2'b11
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e          kind;
        logic [COORD_W-1:0] dst_x;
        logic [COORD_W-1:0] dst_y;
        logic [COORD_W-1:0] src_x;
        logic [COORD_W-1:0] src_y;
        logic [17:0]        spare;
    } ctl_pkt_t;

    localparam logic [PIDX_W-1:0] PORT_XP = 2'd0;
    localparam logic [PIDX_W-1:0] PORT_XN = 2'd1;
    localparam logic [PIDX_W-1:0] PORT_YP = 2'd2;
    localparam logic [PIDX_W-1:0] PORT_YN = 2'd3;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FWD_SETUP,
        ACT_FWD_TEAR,
        ACT_DROP,
        ACT_ARRIVE,
        ACT_DISCARD
    } route_act_e;

    typedef enum logic {
        CH_FREE,
        CH_HELD
    } chan_state_e;
endpackage

// File: rtl/crt_xy_route.sv
module crt_xy_route
    import crt_pkg::*;
#(
    parameter int TORUS_N = 6
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [PIDX_W-1:0]  out_port,
    output logic               at_dest
);
    localparam int DW = COORD_W + 1;
    localparam logic [DW-1:0] RING  = DW'(TORUS_N);
    localparam logic [DW-1:0] HALFR = DW'(TORUS_N / 2);

    logic [DW-1:0] off_x;
    logic [DW-1:0] off_y;

    function automatic logic [DW-1:0] ring_off(input logic [COORD_W-1:0] dst,
                                               input logic [COORD_W-1:0] here);
        logic [DW-1:0] d;
        logic [DW-1:0] h;
        d = {1'b0, dst};
        h = {1'b0, here};
        if (d >= h) return d - h;
        else        return d + RING - h;
    endfunction

    always_comb begin
        off_x    = ring_off(dst_x, here_x);
        off_y    = ring_off(dst_y, here_y);
        at_dest  = 1'b0;
        out_port = PORT_XP;
        if (off_x != '0) begin
            out_port = (off_x <= HALFR) ? PORT_XP : PORT_XN;
        end else if (off_y != '0) begin
            out_port = (off_y <= HALFR) ? PORT_YP : PORT_YN;
        end else begin
            at_dest = 1'b1;
        end
    end
endmodule

// File: rtl/crt_rr_arb.sv
module crt_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 any_gnt
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] idx;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any_gnt = 1'b0;
        idx     = '0;
        for (int k = 0; k < N; k++) begin
            idx = ptr_q + k[IW-1:0];
            if (!any_gnt && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = idx;
                any_gnt  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (any_gnt) ptr_q <= gnt_idx + 1'b1;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R9
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0); // R9
    AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n) (req != '0) |-> any_gnt); // R9
endmodule

// File: rtl/crt_out_chan.sv
module crt_out_chan
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic              release_req,
    input  logic [PIDX_W-1:0] claim_src,
    output logic              held,
    output logic [PIDX_W-1:0] owner
);
    chan_state_e       st_q;
    chan_state_e       st_d;
    logic [PIDX_W-1:0] owner_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_FREE: if (claim)       st_d = CH_HELD;
            CH_HELD: if (release_req) st_d = CH_FREE;
            default:                  st_d = CH_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CH_FREE;
            owner_q <= '0;
        end else begin
            st_q <= st_d;
            if (claim && st_q == CH_FREE) owner_q <= claim_src;
        end
    end

    always_comb begin
        held  = (st_q == CH_HELD);
        owner = owner_q;
    end

    AST_CLAIM_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n) claim |-> st_q == CH_FREE); // R5
    AST_RELEASE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n) release_req |-> st_q == CH_HELD); // R7
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (st_q == CH_HELD && !release_req) |=> (st_q == CH_HELD && $stable(owner_q))); // R4
endmodule

// File: rtl/circuit_router.sv
module circuit_router
    import crt_pkg::*;
#(
    parameter int TORUS_N = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [COORD_W-1:0]       node_x,
    input  logic [COORD_W-1:0]       node_y,
    input  logic [NPORT-1:0]         in_valid,
    input  logic [NPORT*PKT_W-1:0]   in_pkt,
    output logic [NPORT-1:0]         in_gnt,
    output logic [NPORT-1:0]         out_valid,
    output logic [NPORT*PKT_W-1:0]   out_pkt,
    output logic [NPORT*NPORT-1:0]   sw_on,
    output logic                     drop_valid,
    output logic [COORD_W-1:0]       drop_src_x,
    output logic [COORD_W-1:0]       drop_src_y,
    output logic                     arrive_valid,
    output logic [COORD_W-1:0]       arrive_src_x,
    output logic [COORD_W-1:0]       arrive_src_y
);
    logic [PIDX_W-1:0] gidx;
    logic              any_gnt;
    ctl_pkt_t          sel;
    logic [PIDX_W-1:0] rport;
    logic              at_dest;
    route_act_e        act;
    logic [NPORT-1:0]  held;
    logic [PIDX_W-1:0] owner [NPORT];
    logic [NPORT-1:0]  claim;
    logic [NPORT-1:0]  rel;

    crt_rr_arb #(.N(NPORT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (in_valid),
        .gnt     (in_gnt),
        .gnt_idx (gidx),
        .any_gnt (any_gnt)
    );

    always_comb sel = ctl_pkt_t'(in_pkt[gidx*PKT_W +: PKT_W]);

    crt_xy_route #(.TORUS_N(TORUS_N)) u_route (
        .here_x   (node_x),
        .here_y   (node_y),
        .dst_x    (sel.dst_x),
        .dst_y    (sel.dst_y),
        .out_port (rport),
        .at_dest  (at_dest)
    );

    always_comb begin
        act = ACT_IDLE;
        if (any_gnt) begin
            unique case (sel.kind)
                PK_SETUP: begin
                    if (at_dest)           act = ACT_ARRIVE;
                    else if (held[rport])  act = ACT_DROP;
                    else                   act = ACT_FWD_SETUP;
                end
                PK_TEAR: begin
                    if (!at_dest && held[rport] && owner[rport] == gidx)
                        act = ACT_FWD_TEAR;
                    else
                        act = ACT_DISCARD;
                end
                default: act = ACT_DISCARD;
            endcase
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_chan
        always_comb begin
            claim[o] = (act == ACT_FWD_SETUP) && (rport == PIDX_W'(o));
            rel[o]   = (act == ACT_FWD_TEAR)  && (rport == PIDX_W'(o));
        end

        crt_out_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .claim       (claim[o]),
            .release_req (rel[o]),
            .claim_src   (gidx),
            .held        (held[o]),
            .owner       (owner[o])
        );

        for (genvar i = 0; i < NPORT; i++) begin : g_x
            always_comb sw_on[i*NPORT+o] = held[o] && (owner[o] == PIDX_W'(i));
        end

        logic [NPORT-1:0] col;
        for (genvar i = 0; i < NPORT; i++) begin : g_col
            always_comb col[i] = sw_on[i*NPORT+o];
        end
        AST_COL_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col)); // R11
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= '0;
            out_pkt      <= '0;
            drop_valid   <= 1'b0;
            drop_src_x   <= '0;
            drop_src_y   <= '0;
            arrive_valid <= 1'b0;
            arrive_src_x <= '0;
            arrive_src_y <= '0;
        end else begin
            out_valid    <= '0;
            drop_valid   <= 1'b0;
            arrive_valid <= 1'b0;
            unique case (act)
                ACT_FWD_SETUP, ACT_FWD_TEAR: begin
                    out_valid[rport]                 <= 1'b1;
                    out_pkt[rport*PKT_W +: PKT_W]    <= sel;
                end
                ACT_DROP: begin
                    drop_valid <= 1'b1;
                    drop_src_x <= sel.src_x;
                    drop_src_y <= sel.src_y;
                end
                ACT_ARRIVE: begin
                    arrive_valid <= 1'b1;
                    arrive_src_x <= sel.src_x;
                    arrive_src_y <= sel.src_y;
                end
                default: ;
            endcase
        end
    end

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({out_valid, drop_valid, arrive_valid})); // R9
    AST_DROP_KEEPS_SW: assert property (@(posedge clk) disable iff (!rst_n) drop_valid |-> $stable(sw_on)); // R5
    AST_ARRIVE_KEEPS_SW: assert property (@(posedge clk) disable iff (!rst_n) arrive_valid |-> $stable(sw_on)); // R8
    AST_GRANT_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n) (in_valid != '0) |-> (in_gnt != '0)); // R9
endmodule

// File: tb/circuit_router_test.sv
module circuit_router_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   node_x, node_y;
    logic [3:0]   in_valid;
    logic [127:0] in_pkt;
    logic [3:0]   in_gnt;
    logic [3:0]   out_valid;
    logic [127:0] out_pkt;
    logic [15:0]  sw_on;
    logic         drop_valid, arrive_valid;
    logic [2:0]   drop_src_x, drop_src_y, arrive_src_x, arrive_src_y;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    circuit_router #(.TORUS_N(6)) uut (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .in_valid(in_valid), .in_pkt(in_pkt), .in_gnt(in_gnt),
        .out_valid(out_valid), .out_pkt(out_pkt), .sw_on(sw_on),
        .drop_valid(drop_valid), .drop_src_x(drop_src_x), .drop_src_y(drop_src_y),
        .arrive_valid(arrive_valid), .arrive_src_x(arrive_src_x), .arrive_src_y(arrive_src_y)
    );

    function automatic logic [31:0] mk(input logic [1:0] k, input logic [2:0] dx, input logic [2:0] dy,
                                       input logic [2:0] sx, input logic [2:0] sy);
        return {k, dx, dy, sx, sy, 18'h2A5A5};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = '0; in_pkt = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int p, input logic [31:0] pkt);
        @(negedge clk);
        in_valid[p] = 1'b1;
        in_pkt[p*32 +: 32] = pkt;
        @(posedge clk);
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 sw_on", 128'(sw_on), 0);
        chk("R10 out_valid", 128'(out_valid), 0);
        chk("R10 pulses", 128'({drop_valid, arrive_valid}), 0);
        chk("R10 gnt", 128'(in_gnt), 0);
    endtask

    task automatic route_case(input logic [2:0] dx, input logic [2:0] dy, input int exp_o, input string req);
        logic [31:0] pk;
        do_reset();
        pk = mk(2'b01, dx, dy, 3'd1, 3'd1);
        send(0, pk);
        chk(req, 128'(out_valid), 128'(4'b1 << exp_o));
        chk({req, " data"}, 128'(out_pkt[exp_o*32 +: 32]), 128'(pk));
        chk("R4 crossing", 128'(sw_on), 128'(16'b1 << exp_o));
        @(negedge clk);
        chk("R4 one cycle", 128'(out_valid), 0);
    endtask

    task automatic t_routes();
        route_case(3'd4, 3'd2, 0, "R3 dx=2 positive");
        route_case(3'd5, 3'd2, 0, "R3 tie positive");
        route_case(3'd0, 3'd2, 1, "R3 wrap negative");
        route_case(3'd1, 3'd2, 1, "R3 dx=5 negative");
        route_case(3'd2, 3'd5, 2, "R3 Y tie positive");
        route_case(3'd2, 3'd1, 3, "R3 Y negative");
        route_case(3'd3, 3'd5, 0, "R2 X before Y");
        route_case(3'd1, 3'd0, 1, "R2 X before Y neg");
    endtask

    task automatic t_drop();
        do_reset();
        send(1, mk(2'b01, 3'd4, 3'd2, 3'd0, 3'd0));
        chk("R4 reserve", 128'(sw_on), 128'(16'h0010));
        send(3, mk(2'b01, 3'd5, 3'd0, 3'd1, 3'd4));
        chk("R5 drop pulse", 128'(drop_valid), 1);
        chk("R5 drop src", 128'({drop_src_x, drop_src_y}), 128'({3'd1, 3'd4}));
        chk("R5 no forward", 128'(out_valid), 0);
        chk("R5 sw kept", 128'(sw_on), 128'(16'h0010));
        @(negedge clk);
        chk("R5 pulse ends", 128'(drop_valid), 0);
    endtask

    task automatic t_teardown();
        logic [31:0] tp;
        do_reset();
        send(1, mk(2'b01, 3'd4, 3'd2, 3'd0, 3'd0));
        send(2, mk(2'b10, 3'd4, 3'd2, 3'd0, 3'd0));
        chk("R7 foreign tear no out", 128'(out_valid), 0);
        chk("R7 foreign tear sw kept", 128'(sw_on), 128'(16'h0010));
        send(0, mk(2'b10, 3'd1, 3'd2, 3'd0, 3'd0));
        chk("R7 free tear no out", 128'(out_valid), 0);
        tp = mk(2'b10, 3'd4, 3'd2, 3'd0, 3'd0);
        send(1, tp);
        chk("R6 tear forward", 128'(out_valid), 128'(4'b0001));
        chk("R6 tear data", 128'(out_pkt[31:0]), 128'(tp));
        chk("R6 crossing off", 128'(sw_on), 0);
        send(2, mk(2'b01, 3'd4, 3'd2, 3'd3, 3'd3));
        chk("R6 reuse", 128'(sw_on), 128'(16'h0100));
    endtask

    task automatic t_arrive_invalid();
        do_reset();
        send(2, mk(2'b01, 3'd2, 3'd2, 3'd5, 3'd3));
        chk("R8 arrive pulse", 128'(arrive_valid), 1);
        chk("R8 arrive src", 128'({arrive_src_x, arrive_src_y}), 128'({3'd5, 3'd3}));
        chk("R8 no reserve", 128'({sw_on, out_valid}), 0);
        @(negedge clk);
        chk("R8 pulse ends", 128'(arrive_valid), 0);
        send(2, mk(2'b10, 3'd2, 3'd2, 3'd5, 3'd3));
        chk("R8 tear at dest", 128'({sw_on, out_valid, arrive_valid}), 0);
        send(0, mk(2'b00, 3'd4, 3'd2, 3'd1, 3'd1));
        chk("R1 kind 00 ignored", 128'({sw_on, out_valid, drop_valid, arrive_valid}), 0);
        send(0, mk(2'b11, 3'd4, 3'd2, 3'd1, 3'd1));
        chk("R1 kind 11 ignored", 128'({sw_on, out_valid, drop_valid, arrive_valid}), 0);
    endtask

    task automatic t_arb();
        do_reset();
        send(2, mk(2'b01, 3'd2, 3'd5, 3'd0, 3'd0));
        @(negedge clk);
        in_pkt[32 +: 32] = mk(2'b01, 3'd4, 3'd2, 3'd0, 3'd0);
        in_pkt[96 +: 32] = mk(2'b01, 3'd0, 3'd2, 3'd0, 3'd0);
        in_valid = 4'b1010;
        #1 chk("R9 rr after 2 picks 3", 128'(in_gnt), 128'(4'b1000));
        @(posedge clk); @(negedge clk);
        chk("R9 first served", 128'(out_valid), 128'(4'b0010));
        in_valid[3] = 1'b0;
        #1 chk("R9 waiting input", 128'(in_gnt), 128'(4'b0010));
        @(posedge clk); @(negedge clk);
        chk("R9 second served", 128'(out_valid), 128'(4'b0001));
        in_valid = '0;
        chk("R9 crossings", 128'(sw_on), 128'(16'h2410));
        in_pkt[0 +: 32] = mk(2'b00, 3'd0, 3'd0, 3'd0, 3'd0);
        in_valid = 4'b1001;
        #1 chk("R9 rr after 1 picks 3", 128'(in_gnt), 128'(4'b1000));
        @(posedge clk); @(negedge clk);
        in_valid[3] = 1'b0;
        #1 chk("R9 wrap to 0", 128'(in_gnt), 128'(4'b0001));
        @(posedge clk); @(negedge clk);
        in_valid = '0;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = '0; in_pkt = '0;
        node_x = 3'd2; node_y = 3'd2;
        t_reset();
        t_routes();
        t_drop();
        t_teardown();
        t_arrive_invalid();
        t_arb();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule